// File: doc/BRIEF.md
# Load-Group Instruction Sequencer

This block runs the data-movement subset of a classic 8-bit processor: moves between registers, loads of immediate bytes and words, and byte loads and stores through the HL pointer or through an index register plus a signed offset. It holds the working registers itself: seven byte registers, the stack pointer and two index registers. It fetches its own opcode and operand bytes through a byte-wide memory port that has a combinational read.

Each clock edge completes one machine cycle. The block keeps a running total of the T-states consumed, computed from the length of each machine cycle, and reports the T-state cost of every instruction as it retires. A halt opcode stops the sequencer until reset. An opcode outside the group is retired with an unsupported pulse and leaves every register untouched. None of these instructions has any flag to alter.

Top module: `ldseq_core`

## Requirements
- R1: While reset is asserted, pc reads 0, t_total reads 0, sp reads 0 and instr_done, unsupported, halted and mem_wr are all low. All byte registers, SP, IX and IY clear to 0.
- R2: Opcode 01dddsss with neither field equal to 110 copies register sss into register ddd in 4 T-states. Register codes: B=000, C=001, D=010, E=011, H=100, L=101, A=111.
- R3: Opcode 00rrr110 with rrr not 110 loads the following byte into register rrr in 7 T-states (4+3).
- R4: Opcode 01rrr110 (not 76h) reads the byte at address HL into rrr, and opcode 01110rrr (not 76h) writes rrr to address HL, each in 7 T-states (4+3).
- R5: Opcode 36h followed by a byte writes that byte to address HL in 10 T-states (4+3+3).
- R6: Opcode 76h performs no load or store, retires in 4 T-states and asserts halted. While halted, no memory access occurs and pc and t_total hold until reset.
- R7: Prefix DDh selects IX and FDh selects IY. A following 01rrr110 or 01110rrr opcode (not 76h) loads or stores through address index + sign-extended displacement byte, modulo 65536, in 19 T-states (4+4+3+5+3).
- R8: Opcode 00pp0001 loads the next two bytes, low byte first, into pair pp (BC=00, DE=01, HL=10, SP=11) in 10 T-states (4+3+3). For BC, DE and HL, the high byte lands in B, D or H.
- R9: DDh 21h or FDh 21h loads the next two bytes, low byte first, into IX or IY in 14 T-states (4+4+3+3).
- R10: A prefix followed by any other opcode retires after 8 T-states, and an unprefixed opcode outside the group retires after 4 T-states. In both cases unsupported pulses with instr_done and no register or memory location is written.
- R11: When an instruction retires, instr_done pulses for one cycle with instr_t holding its T-state count. t_total always equals the sum of all retired counts, and pc has advanced by the number of instruction bytes consumed.
- R12: mem_rd and mem_wr are never both high, and a single instruction never writes a byte register and a register pair in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | ADDR_W | Memory address of the current machine cycle |
| mem_rd | output | 1 | Read strobe; data is taken from mem_rdata at the clock edge |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Read data, valid in the same cycle as mem_addr |
| pc | output | ADDR_W | Address of the next instruction-stream byte |
| sp | output | ADDR_W | Current stack pointer value |
| instr_done | output | 1 | One-cycle pulse when an instruction retires |
| instr_t | output | 5 | T-states of the retired instruction |
| unsupported | output | 1 | Pulses with instr_done when the opcode was outside the group |
| halted | output | 1 | High once a halt opcode has retired |
| t_total | output | TCNT_W | Running total of elapsed T-states |

## Verification
The hardest behaviour to reach from the ports is that a move actually copies one named register into another. Register contents are visible only after further instructions store them to memory. The bench therefore builds one small program for each of the 49 destination/source pairs. Each program seeds all seven registers with distinct values, does the move, and then dumps every register through indexed stores into a scratch area that the bench compares against its own model. Negative displacements, address wrap at the top of the 64K space, and the prefixed opcodes that are unsupported are reached by programs built the same way. The bench then compares the retired T-state sequence against the cost table in the requirements.

// File: rtl/ldseq_pkg.sv
`timescale 1ns/1ps
package ldseq_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_FETCH_X, ST_IMM, ST_HL_RD, ST_HL_WR, ST_HL_WRN,
    ST_LO, ST_HI, ST_DISP, ST_ADDR, ST_X_RD, ST_X_WR, ST_HALT
  } seq_state_t;

  typedef enum logic [3:0] {
    OP_MOVE, OP_LD_PTR, OP_ST_PTR, OP_IMM8, OP_IMM_PTR, OP_IMM16,
    OP_PREFIX, OP_HALT, OP_BAD
  } op_class_t;

  // pair select: the first four follow the pp field of the 16-bit load
  typedef enum logic [2:0] {
    PAIR_BC = 3'd0, PAIR_DE = 3'd1, PAIR_HL = 3'd2, PAIR_SP = 3'd3,
    PAIR_IX = 3'd4, PAIR_IY = 3'd5
  } pair_sel_t;

  localparam logic [2:0] RCODE_PTR    = 3'b110;
  localparam logic [7:0] OPC_HALT     = 8'h76;
  localparam logic [7:0] OPC_PFX_X    = 8'hDD;
  localparam logic [7:0] OPC_PFX_Y    = 8'hFD;
  localparam logic [7:0] OPC_IDX_IMM  = 8'h21;
  localparam logic [7:0] OPC_PTR_IMM  = 8'h36;
  localparam int         TSTATE_W     = 5;

  // T-states of each machine cycle kind
  function automatic logic [TSTATE_W-1:0] mcycle_len(seq_state_t s);
    case (s)
      ST_FETCH, ST_FETCH_X: mcycle_len = TSTATE_W'(4);
      ST_ADDR:              mcycle_len = TSTATE_W'(5);
      ST_HALT:              mcycle_len = TSTATE_W'(0);
      default:              mcycle_len = TSTATE_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/ldseq_decode.sv
`timescale 1ns/1ps
module ldseq_decode
  import ldseq_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       prefixed,
  output op_class_t  cls
);

  logic is_row01, is_row00, src_ptr, dst_ptr;

  assign is_row01 = (opcode[7:6] == 2'b01);
  assign is_row00 = (opcode[7:6] == 2'b00);
  assign src_ptr  = (opcode[2:0] == RCODE_PTR);
  assign dst_ptr  = (opcode[5:3] == RCODE_PTR);

  always_comb begin
    cls = OP_BAD;
    if (!prefixed) begin
      if (opcode == OPC_PFX_X || opcode == OPC_PFX_Y)  cls = OP_PREFIX;
      else if (opcode == OPC_HALT)                     cls = OP_HALT;
      else if (is_row01 && src_ptr)                    cls = OP_LD_PTR;
      else if (is_row01 && dst_ptr)                    cls = OP_ST_PTR;
      else if (is_row01)                               cls = OP_MOVE;
      else if (is_row00 && src_ptr)                    cls = dst_ptr ? OP_IMM_PTR : OP_IMM8;
      else if (is_row00 && opcode[3:0] == 4'b0001)     cls = OP_IMM16;
    end else begin
      if (opcode == OPC_IDX_IMM)                       cls = OP_IMM16;
      else if (opcode == OPC_HALT)                     cls = OP_BAD;
      else if (is_row01 && src_ptr)                    cls = OP_LD_PTR;
      else if (is_row01 && dst_ptr)                    cls = OP_ST_PTR;
    end
  end

endmodule

// File: rtl/ldseq_ea.sv
`timescale 1ns/1ps
module ldseq_ea #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{EXT_W{disp[DATA_W-1]}}, disp};
  assign ea      = base + disp_sx;  // wraps modulo 2**ADDR_W

endmodule

// File: rtl/ldseq_regs.sv
`timescale 1ns/1ps
module ldseq_regs
  import ldseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we8,
  input  logic [2:0]        wsel8,
  input  logic [DATA_W-1:0] wdata8,
  input  logic [2:0]        rsel8,
  output logic [DATA_W-1:0] rdata8,
  input  logic              we16,
  input  pair_sel_t         wsel16,
  input  logic [ADDR_W-1:0] wdata16,
  output logic [ADDR_W-1:0] hl_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] ix_o,
  output logic [ADDR_W-1:0] iy_o
);

  localparam int NREG     = 8;
  localparam int NPAIRREG = 6;

  logic [NREG-1:0][DATA_W-1:0] gview;
  logic [ADDR_W-1:0] sp_q, ix_q, iy_q;

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    if (g == 6) begin : g_hole
      assign gview[g] = '0;
    end else begin : g_reg
      localparam int  PIDX  = g / 2;
      localparam bit  UPPER = (g % 2) == 0;
      logic              hit8, hit16;
      logic [DATA_W-1:0] nxt, r_q;

      assign hit8 = we8 && (wsel8 == 3'(g));
      if (g < NPAIRREG) begin : g_pair
        assign hit16 = we16 && (3'(wsel16) == 3'(PIDX));
      end else begin : g_solo
        assign hit16 = 1'b0;
      end

      always_comb begin
        if (hit16) nxt = UPPER ? wdata16[ADDR_W-1 -: DATA_W] : wdata16[DATA_W-1:0];
        else       nxt = wdata8;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              r_q <= '0;
        else if (hit8 || hit16)  r_q <= nxt;
      end

      assign gview[g] = r_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sp_q <= '0;
    else if (we16 && wsel16 == PAIR_SP)  sp_q <= wdata16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ix_q <= '0;
    else if (we16 && wsel16 == PAIR_IX)  ix_q <= wdata16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          iy_q <= '0;
    else if (we16 && wsel16 == PAIR_IY)  iy_q <= wdata16;
  end

  assign rdata8 = gview[rsel8];
  assign hl_o   = {gview[4], gview[5]};
  assign sp_o   = sp_q;
  assign ix_o   = ix_q;
  assign iy_o   = iy_q;

  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    we8 |-> !we16) else $error("byte and pair write together"); // R12

  AST_NO_PTR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    we8 |-> wsel8 != RCODE_PTR) else $error("write to pointer code"); // R4

endmodule

// File: rtl/ldseq_core.sv
`timescale 1ns/1ps
module ldseq_core
  import ldseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int TCNT_W   = 24,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   sp,
  output logic                instr_done,
  output logic [TSTATE_W-1:0] instr_t,
  output logic                unsupported,
  output logic                halted,
  output logic [TCNT_W-1:0]   t_total
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  seq_state_t          state_q, state_d;
  logic [ADDR_W-1:0]   pc_q, pc_d, ea_q, ea_d;
  logic [7:0]          op_q, op_d;
  logic [DATA_W-1:0]   imm_q, imm_d;
  logic                iy_q, iy_d, pfx_q, pfx_d;
  logic [TSTATE_W-1:0] tacc_q, tacc_d, tret_q, tret_d, cyc_t, t_now;
  logic                done_q, done_d, unsup_q, unsup_d;
  logic [TCNT_W-1:0]   ttot_q, ttot_d;

  op_class_t           cls;
  logic                we8, we16;
  logic [2:0]          wsel8, rsel8;
  logic [DATA_W-1:0]   wdata8, rdata8;
  pair_sel_t           wsel16;
  logic [ADDR_W-1:0]   wdata16, hl, ix, iy, ea_calc;

  ldseq_decode u_dec (
    .opcode   (mem_rdata[7:0]),
    .prefixed (state_q == ST_FETCH_X),
    .cls      (cls)
  );

  ldseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .we8     (we8),
    .wsel8   (wsel8),
    .wdata8  (wdata8),
    .rsel8   (rsel8),
    .rdata8  (rdata8),
    .we16    (we16),
    .wsel16  (wsel16),
    .wdata16 (wdata16),
    .hl_o    (hl),
    .sp_o    (sp),
    .ix_o    (ix),
    .iy_o    (iy)
  );

  ldseq_ea #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ea (
    .base (iy_q ? iy : ix),
    .disp (imm_q),
    .ea   (ea_calc)
  );

  assign cyc_t = mcycle_len(state_q);
  assign t_now = (state_q == ST_FETCH) ? cyc_t : tacc_q + cyc_t;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    op_d      = op_q;
    imm_d     = imm_q;
    ea_d      = ea_q;
    iy_d      = iy_q;
    pfx_d     = pfx_q;
    tacc_d    = t_now;
    tret_d    = tret_q;
    done_d    = 1'b0;
    unsup_d   = 1'b0;
    ttot_d    = ttot_q + TCNT_W'(cyc_t);
    mem_addr  = pc_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = rdata8;
    we8       = 1'b0;
    wsel8     = op_q[5:3];
    wdata8    = mem_rdata;
    rsel8     = op_q[2:0];
    we16      = 1'b0;
    wsel16    = pfx_q ? (iy_q ? PAIR_IY : PAIR_IX) : pair_sel_t'({1'b0, op_q[5:4]});
    wdata16   = {mem_rdata, imm_q};

    case (state_q)
      ST_FETCH: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + 1'b1;
        op_d   = mem_rdata;
        iy_d   = 1'b0;
        pfx_d  = 1'b0;
        rsel8  = mem_rdata[2:0];
        case (cls)
          OP_PREFIX: begin
            pfx_d   = 1'b1;
            iy_d    = (mem_rdata == OPC_PFX_Y);
            state_d = ST_FETCH_X;
          end
          OP_HALT: begin
            done_d = 1'b1; tret_d = t_now; state_d = ST_HALT;
          end
          OP_MOVE: begin
            we8    = 1'b1;
            wsel8  = mem_rdata[5:3];
            wdata8 = rdata8;
            done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
          end
          OP_LD_PTR:            state_d = ST_HL_RD;
          OP_ST_PTR:            state_d = ST_HL_WR;
          OP_IMM8, OP_IMM_PTR:  state_d = ST_IMM;
          OP_IMM16:             state_d = ST_LO;
          default: begin
            unsup_d = 1'b1; done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
          end
        endcase
      end
      ST_FETCH_X: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + 1'b1;
        op_d   = mem_rdata;
        case (cls)
          OP_LD_PTR, OP_ST_PTR: state_d = ST_DISP;
          OP_IMM16:             state_d = ST_LO;
          default: begin
            unsup_d = 1'b1; done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
          end
        endcase
      end
      ST_IMM: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + 1'b1;
        if (op_q == OPC_PTR_IMM) begin
          imm_d   = mem_rdata;
          state_d = ST_HL_WRN;
        end else begin
          we8    = 1'b1;
          done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
        end
      end
      ST_HL_RD: begin
        mem_addr = hl;
        mem_rd   = 1'b1;
        we8      = 1'b1;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      ST_HL_WR: begin
        mem_addr = hl;
        mem_wr   = 1'b1;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      ST_HL_WRN: begin
        mem_addr  = hl;
        mem_wr    = 1'b1;
        mem_wdata = imm_q;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      ST_LO: begin
        mem_rd  = 1'b1;
        pc_d    = pc_q + 1'b1;
        imm_d   = mem_rdata;
        state_d = ST_HI;
      end
      ST_HI: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + 1'b1;
        we16   = 1'b1;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      ST_DISP: begin
        mem_rd  = 1'b1;
        pc_d    = pc_q + 1'b1;
        imm_d   = mem_rdata;
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        ea_d    = ea_calc;
        state_d = (op_q[2:0] == RCODE_PTR) ? ST_X_RD : ST_X_WR;
      end
      ST_X_RD: begin
        mem_addr = ea_q;
        mem_rd   = 1'b1;
        we8      = 1'b1;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      ST_X_WR: begin
        mem_addr = ea_q;
        mem_wr   = 1'b1;
        done_d = 1'b1; tret_d = t_now; state_d = ST_FETCH;
      end
      default: begin
        tacc_d = tacc_q;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      op_q    <= '0;
      imm_q   <= '0;
      ea_q    <= '0;
      iy_q    <= 1'b0;
      pfx_q   <= 1'b0;
      tacc_q  <= '0;
      tret_q  <= '0;
      done_q  <= 1'b0;
      unsup_q <= 1'b0;
      ttot_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      op_q    <= op_d;
      imm_q   <= imm_d;
      ea_q    <= ea_d;
      iy_q    <= iy_d;
      pfx_q   <= pfx_d;
      tacc_q  <= tacc_d;
      tret_q  <= tret_d;
      done_q  <= done_d;
      unsup_q <= unsup_d;
      ttot_q  <= ttot_d;
    end
  end

  assign pc          = pc_q;
  assign instr_done  = done_q;
  assign instr_t     = tret_q;
  assign unsupported = unsup_q;
  assign halted      = (state_q == ST_HALT);
  assign t_total     = ttot_q;

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(mem_rd && mem_wr)) else $error("read and write together"); // R12

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_s_n)
    halted |=> halted && !mem_rd && !mem_wr && $stable(pc) && $stable(t_total))
    else $error("activity while halted"); // R6

  AST_T_LEGAL: assert property (@(posedge clk) disable iff (!rst_s_n)
    instr_done |-> (instr_t == 5'd4 || instr_t == 5'd7 || instr_t == 5'd8 ||
                    instr_t == 5'd10 || instr_t == 5'd14 || instr_t == 5'd19))
    else $error("illegal instruction cost"); // R11

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    unsup_d |-> !we8 && !we16 && !mem_wr) else $error("unsupported op wrote"); // R10

  AST_UNSUP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    unsupported |-> instr_done) else $error("unsupported without retire"); // R10

endmodule

// File: tb/sim_ldseq_core.sv
`timescale 1ns/1ps
module sim_ldseq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, pc, sp;
  logic        mem_rd, mem_wr, instr_done, unsupported, halted;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  instr_t;
  logic [23:0] t_total;

  always #10 clk = ~clk;  // 50 MHz

  ldseq_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .instr_done(instr_done), .instr_t(instr_t),
    .unsupported(unsupported), .halted(halted), .t_total(t_total)
  );

  logic [7:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;

  int nchk = 0, nfail = 0;
  logic [7:0] prog [0:127];
  int plen, nins, exptot, nseen, unsup_cnt, halt_acc;
  int expt [0:63];
  int seen_t [0:63];
  logic [7:0] rv [0:7];  // bench model of byte registers
  int codes [0:6] = '{0, 1, 2, 3, 4, 5, 7};

  always @(negedge clk) begin
    if (rst_n) begin
      if (instr_done) begin
        if (nseen < 64) seen_t[nseen] = int'(instr_t);
        nseen++;
        if (unsupported) unsup_cnt++;
      end
      if (halted && (mem_rd || mem_wr)) halt_acc++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    prog[plen] = b; plen++;
  endtask
  task automatic ins(input int t);
    expt[nins] = t; nins++; exptot += t;
  endtask
  task automatic new_prog();
    plen = 0; nins = 0; exptot = 0;
  endtask
  task automatic op_imm8(input int c, input logic [7:0] v);
    emit(8'((c << 3) | 6)); emit(v); ins(7); rv[c] = v;
  endtask
  task automatic op_imm16(input int pp, input logic [15:0] v);
    emit(8'((pp << 4) | 1)); emit(v[7:0]); emit(v[15:8]); ins(10);
  endtask
  task automatic op_idx16(input bit use_y, input logic [15:0] v);
    emit(use_y ? 8'hFD : 8'hDD); emit(8'h21); emit(v[7:0]); emit(v[15:8]); ins(14);
  endtask
  task automatic op_st_x(input bit use_y, input int c, input logic [7:0] d);
    emit(use_y ? 8'hFD : 8'hDD); emit(8'(8'h70 | c)); emit(d); ins(19);
  endtask
  task automatic op_ld_x(input bit use_y, input int c, input logic [7:0] d);
    emit(use_y ? 8'hFD : 8'hDD); emit(8'(8'h46 | (c << 3))); emit(d); ins(19);
  endtask
  task automatic dump_regs();  // IX must hold 0x0300
    for (int k = 0; k < 7; k++) op_st_x(1'b0, codes[k], 8'(codes[k]));
  endtask
  task automatic op_halt();
    emit(8'h76); ins(4);
  endtask

  task automatic run_prog(input string tag);
    int k;
    logic [15:0] pc_h;
    logic [23:0] tt_h;
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < plen; i++) mem[i] = prog[i];
    nseen = 0; unsup_cnt = 0; halt_acc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    while (!halted && k < 3000) begin @(negedge clk); k++; end
    chk({tag, " R6 halt reached"}, int'(halted), 1);
    repeat (2) @(negedge clk);
    chk({tag, " R11 t_total"}, int'(t_total), exptot);
    chk({tag, " R11 pc"}, int'(pc), plen);
    chk({tag, " R11 retire count"}, nseen, nins);
    for (int i = 0; i < nins && i < 64; i++)
      chk({tag, $sformatf(" R11 instr %0d cost", i)}, seen_t[i], expt[i]);
    pc_h = pc; tt_h = t_total;
    repeat (8) @(negedge clk);
    chk({tag, " R6 pc held"}, int'(pc), int'(pc_h));
    chk({tag, " R6 t_total held"}, int'(t_total), int'(tt_h));
    chk({tag, " R6 no access when halted"}, halt_acc, 0);
  endtask

  task automatic check_dump(input string tag);
    for (int k = 0; k < 7; k++)
      chk($sformatf("%s reg code %0d", tag, codes[k]),
          int'(mem[10'h300 + codes[k]]), int'(rv[codes[k]]));
  endtask

  task automatic clear_scratch();
    for (int i = 10'h200; i < 1024; i++) mem[i] = 8'h00;
  endtask

  initial begin
    int d, s;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pc", int'(pc), 0);
    chk("R1 t_total", int'(t_total), 0);
    chk("R1 instr_done", int'(instr_done), 0);
    chk("R1 unsupported", int'(unsupported), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 sp", int'(sp), 0);

    // R2 all destination/source pairs, seeded by R3 immediates
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        d = codes[a]; s = codes[b];
        clear_scratch();
        new_prog();
        for (int k = 0; k < 7; k++)
          op_imm8(codes[k], 8'(codes[k] * 37 + d * 5 + s * 11 + 3));
        op_idx16(1'b0, 16'h0300);
        emit(8'(8'h40 | (d << 3) | s)); ins(4);
        rv[d] = rv[s];
        dump_regs();
        op_halt();
        run_prog($sformatf("R2 move %0d<-%0d", d, s));
        check_dump($sformatf("R2 R3 move %0d<-%0d", d, s));
      end
    end

    // R4 pointer loads and stores, R8 pair load of HL
    for (int a = 0; a < 7; a++) begin
      d = codes[a];
      clear_scratch();
      for (int k = 0; k < 7; k++) rv[codes[k]] = 8'h00;
      mem[10'h250] = 8'(8'hA0 + d);
      new_prog();
      op_idx16(1'b0, 16'h0300);
      op_imm16(2, 16'h0250);
      rv[4] = 8'h02; rv[5] = 8'h50;
      emit(8'(8'h46 | (d << 3))); ins(7);
      rv[d] = 8'(8'hA0 + d);
      dump_regs();
      op_imm16(2, 16'h0260);
      emit(8'(8'h70 | d)); ins(7);
      op_halt();
      run_prog($sformatf("R4 ptr %0d", d));
      check_dump($sformatf("R4 load via HL code %0d", d));
      chk($sformatf("R4 store via HL code %0d", d), int'(mem[10'h260]),
          (d == 4) ? 8'h02 : (d == 5) ? 8'h60 : int'(8'hA0 + d));
    end

    // R5 immediate to memory, R8 pairs and SP
    clear_scratch();
    new_prog();
    op_imm16(0, 16'h1234);
    op_imm16(1, 16'h5678);
    op_imm16(3, 16'hBEEF);
    op_imm8(7, 8'h9C);
    op_imm16(2, 16'h0270);
    emit(8'h36); emit(8'h5A); ins(10);
    op_idx16(1'b0, 16'h0300);
    dump_regs();
    op_halt();
    run_prog("R5 R8 words");
    rv[0] = 8'h12; rv[1] = 8'h34; rv[2] = 8'h56; rv[3] = 8'h78;
    rv[4] = 8'h02; rv[5] = 8'h70;
    check_dump("R8 pair load");
    chk("R8 sp load", int'(sp), 16'hBEEF);
    chk("R5 immediate store", int'(mem[10'h270]), 8'h5A);

    // R7 R9 index with negative and positive displacement, wrap
    clear_scratch();
    for (int k = 0; k < 7; k++) mem[10'h230 + codes[k]] = 8'(8'hC0 + codes[k]);
    new_prog();
    op_idx16(1'b1, 16'h0240);
    for (int k = 0; k < 7; k++) begin
      op_ld_x(1'b1, codes[k], 8'(-16 + codes[k]));
      rv[codes[k]] = 8'(8'hC0 + codes[k]);
    end
    op_idx16(1'b0, 16'h0300);
    dump_regs();
    for (int k = 0; k < 7; k++) op_st_x(1'b1, codes[k], 8'(8'h10 + codes[k]));
    op_idx16(1'b0, 16'hFFF0);
    op_st_x(1'b0, 7, 8'h7F);
    op_halt();
    run_prog("R7 index");
    check_dump("R7 R9 index load negative disp");
    for (int k = 0; k < 7; k++)
      chk($sformatf("R7 IY store code %0d", codes[k]),
          int'(mem[10'h250 + codes[k]]), int'(8'hC0 + codes[k]));
    chk("R7 wrapped address", int'(mem[10'h06F]), 8'hC7);

    // R10 unsupported opcodes leave registers alone
    clear_scratch();
    new_prog();
    for (int k = 0; k < 7; k++) op_imm8(codes[k], 8'(8'h61 + k * 9));
    op_idx16(1'b0, 16'h0300);
    emit(8'hDD); emit(8'h40); ins(8);
    emit(8'hFD); emit(8'h76); ins(8);
    emit(8'hDD); emit(8'h0E); ins(8);
    emit(8'h80); ins(4);
    dump_regs();
    op_halt();
    run_prog("R10 unsupported");
    check_dump("R10 registers unchanged");
    chk("R10 unsupported pulses", unsup_cnt, 4);

    // R6 halt opcode is not a pointer-to-pointer move
    clear_scratch();
    mem[10'h280] = 8'h33;
    new_prog();
    op_imm16(2, 16'h0280);
    op_halt();
    run_prog("R6 halt");
    chk("R6 halt did not store", int'(mem[10'h280]), 8'h33);
    chk("R6 no unsupported", unsup_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule